// File: doc/BRIEF.md
# Interval Hit-Rate Weight Tuner

This block sets, while the system runs, the reuse weight that a cache replacement selector gives to hits from the fast (big) cores of an asymmetric multi-core system. It watches a per-cycle strobe that marks a big-core access to the shared cache and a qualifier that marks that access as a hit. It counts accesses and hits over sampling intervals. Each interval closes after a programmable number of big-core accesses.

At each interval boundary the block compares the big-core hit rate of the closing interval with the rate of the interval before it. No divider is used: the hits of each interval are multiplied by the accesses of the other. A strictly better rate raises the big-core weight by one, up to a ceiling equal to the number of big cores. Any other outcome returns the weight to one. The weight for little-core hits is always one. The inputs are plain strobes with no back-pressure: each cycle with the access strobe high counts as exactly one access, and the block can never stall the source. The weight outputs are plain levels that the replacement selector reads every cycle.

Top module: `hit_weight_tuner`

## Requirements
- R1: After reset `weight_big` is 1 and the access and hit tallies are empty.
- R2: An interval closes in the cycle that presents its `interval_len`-th access (`acc_vld`=1). Cycles with `acc_vld`=0 add nothing to either tally, even when `acc_hit`=1. An `interval_len` of 0 behaves as 1.
- R3: When the hit rate of the closing interval is strictly higher than that of the previous interval, `weight_big` rises by 1.
- R4: `weight_big` never rises above `big_cores`. An improvement while it already equals `big_cores` leaves it unchanged.
- R5: When the closing interval's hit rate is equal to or lower than the previous one, `weight_big` returns to 1.
- R6: The first interval after reset has no earlier interval with accesses to compare against, so it counts as no improvement and leaves `weight_big` at 1.
- R7: A new `weight_big` value appears in the cycle after the boundary cycle. Outside boundaries `weight_big` holds its value.
- R8: `weight_little` is 1 at all times.
- R9: Rate comparison is exact across intervals of different lengths. For example, 3 hits in 4 accesses equals 6 in 8, and 3/4 beats 5/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Big-core access in this cycle |
| acc_hit | input | 1 | The access in this cycle hit (ignored when acc_vld=0) |
| big_cores | input | WGT_W | Number of big cores; ceiling for weight_big |
| interval_len | input | CNT_W | Accesses per interval |
| weight_big | output | WGT_W | Reuse weight for big-core hits |
| weight_little | output | WGT_W | Reuse weight for little-core hits (constant 1) |

## Verification
The bench uses the default widths (8-bit interval length, 4-bit weights), with `big_cores` set to 3 and `interval_len` switched between 4 and 8. A three-core ceiling lets a run of rising hit rates reach the cap within a few intervals and then push against it. Switching the interval length brings equal-ratio and higher-ratio comparisons between intervals of different sizes within reach, and these are where cross-multiplication must be exact. Gapped access streams carrying stray hit flags show whether idle cycles leak into the tallies.

// File: rtl/hwt_pkg.sv
package hwt_pkg;
  localparam int unsigned DEF_CNT_W = 8;
  localparam int unsigned DEF_WGT_W = 4;

  typedef enum logic [1:0] {
    CMP_WORSE = 2'd0,
    CMP_BETTER = 2'd1
  } cmp_res_e;
endpackage

// File: rtl/hwt_interval_counter.sv
module hwt_interval_counter #(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned TW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic             acc_hit,
  input  logic [CNT_W-1:0] interval_len,
  output logic             boundary,
  output logic [TW-1:0]    cur_acc,
  output logic [TW-1:0]    cur_hit
);
  logic [TW-1:0] acc_cnt, hit_cnt;
  logic [TW-1:0] len_eff;

  assign len_eff  = (interval_len == '0) ? TW'(1) : TW'(interval_len);
  assign cur_acc  = acc_cnt + TW'(1);
  assign cur_hit  = hit_cnt + TW'(acc_hit);
  assign boundary = acc_vld && (cur_acc >= len_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      hit_cnt <= '0;
    end else if (boundary) begin
      acc_cnt <= '0;
      hit_cnt <= '0;
    end else if (acc_vld) begin
      acc_cnt <= cur_acc;
      hit_cnt <= cur_hit;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> ($stable(acc_cnt) && $stable(hit_cnt)));

  // R2
  hit_le_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt <= acc_cnt);
endmodule

// File: rtl/hwt_rate_compare.sv
module hwt_rate_compare
  import hwt_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned TW = CNT_W + 1,
  localparam int unsigned PW = 2 * TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic [TW-1:0] cur_acc,
  input  logic [TW-1:0] cur_hit,
  output cmp_res_e      result
);
  logic [TW-1:0] prev_acc, prev_hit;
  logic [PW-1:0] lhs, rhs;

  assign lhs = PW'(cur_hit) * PW'(prev_acc);
  assign rhs = PW'(prev_hit) * PW'(cur_acc);
  assign result = ((prev_acc != '0) && (cur_acc != '0) && (lhs > rhs))
                  ? CMP_BETTER : CMP_WORSE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_acc <= '0;
      prev_hit <= '0;
    end else if (boundary) begin
      prev_acc <= cur_acc;
      prev_hit <= cur_hit;
    end
  end

  // R6
  first_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_acc == '0) |-> (result == CMP_WORSE));
endmodule

// File: rtl/hwt_weight_reg.sv
module hwt_weight_reg
  import hwt_pkg::*;
#(
  parameter int unsigned WGT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  cmp_res_e         result,
  input  logic [WGT_W-1:0] big_cores,
  output logic [WGT_W-1:0] weight
);
  localparam logic [WGT_W-1:0] ONE = WGT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      weight <= ONE;
    end else if (boundary) begin
      if (result != CMP_BETTER) weight <= ONE;
      else if (weight < big_cores) weight <= weight + ONE;
    end
  end

  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(weight));

  // R5
  drop_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && result == CMP_WORSE) |=> (weight == ONE));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && result == CMP_BETTER && weight < big_cores)
      |=> (weight == $past(weight) + ONE));

  // R4
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && result == CMP_BETTER && weight >= big_cores)
      |=> $stable(weight));
endmodule

// File: rtl/hit_weight_tuner.sv
module hit_weight_tuner
  import hwt_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned WGT_W = DEF_WGT_W,
  localparam int unsigned TW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic             acc_hit,
  input  logic [WGT_W-1:0] big_cores,
  input  logic [CNT_W-1:0] interval_len,
  output logic [WGT_W-1:0] weight_big,
  output logic [WGT_W-1:0] weight_little
);
  logic          boundary;
  logic [TW-1:0] cur_acc, cur_hit;
  cmp_res_e      result;

  hwt_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_hit(acc_hit),
    .interval_len(interval_len), .boundary(boundary),
    .cur_acc(cur_acc), .cur_hit(cur_hit)
  );

  hwt_rate_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .cur_acc(cur_acc), .cur_hit(cur_hit), .result(result)
  );

  hwt_weight_reg #(.WGT_W(WGT_W)) u_wgt (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .result(result),
    .big_cores(big_cores), .weight(weight_big)
  );

  assign weight_little = WGT_W'(1);

  // R1
  reset_weight_chk: assert property (@(posedge clk)
    !rst_n |=> (weight_big == WGT_W'(1)));
endmodule

// File: tb/hit_weight_tuner_test.sv
module hit_weight_tuner_test;
  localparam int CW = 8;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_vld = 1'b0;
  logic          acc_hit = 1'b0;
  logic [WW-1:0] big_cores = WW'(3);
  logic [CW-1:0] interval_len = CW'(8);
  logic [WW-1:0] weight_big, weight_little;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  hit_weight_tuner #(.CNT_W(CW), .WGT_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_hit(acc_hit),
    .big_cores(big_cores), .interval_len(interval_len),
    .weight_big(weight_big), .weight_little(weight_little)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; acc_vld = 1'b0; acc_hit = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // n accesses with the first h as hits; gap>0 inserts idle cycles
  // carrying a stray hit flag. Checks the weight stays before the last
  // access edge (R7) and returns with the new value sampled.
  task automatic run_interval(input int n, input int h, input int gap,
                              input int old_w, input int new_w, input string req);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i > 0) begin
        for (int g = 0; g < gap; g++) begin
          acc_vld = 1'b0; acc_hit = 1'b1;
          @(negedge clk);
        end
      end
      acc_vld = 1'b1; acc_hit = (i < h);
      if (i == n - 1) check("R7 hold before boundary", weight_big, old_w);
      @(negedge clk);
    end
    acc_vld = 1'b0; acc_hit = 1'b0;
    check(req, weight_big, new_w);
    check("R8 weight_little", weight_little, 1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 weight_big after reset", weight_big, 1);
    check("R8 weight_little after reset", weight_little, 1);
  endtask

  task automatic t_climb_and_cap();
    interval_len = CW'(8);
    run_interval(8, 1, 0, 1, 1, "R6 first interval no improvement");
    run_interval(8, 2, 0, 1, 2, "R3 2/8 beats 1/8");
    run_interval(8, 3, 0, 2, 3, "R3 3/8 beats 2/8");
    run_interval(8, 5, 0, 3, 3, "R4 capped at big_cores");
    run_interval(8, 5, 0, 3, 1, "R5 equal rate resets");
  endtask

  task automatic t_cross_length();
    interval_len = CW'(4);
    run_interval(4, 3, 0, 1, 2, "R9 3/4 beats 5/8");
    interval_len = CW'(8);
    run_interval(8, 6, 0, 2, 1, "R9 6/8 equals 3/4");
    run_interval(8, 0, 0, 1, 1, "R5 lower rate stays 1");
  endtask

  task automatic t_idle_ignored();
    run_interval(8, 1, 2, 1, 2, "R2 gapped interval 1/8 beats 0/8");
    run_interval(8, 2, 0, 2, 3, "R2 stray hits not counted");
    for (int k = 0; k < 5; k++) begin
      acc_vld = 1'b0; acc_hit = 1'b1;
      @(negedge clk);
      check("R7 idle hold", weight_big, 3);
    end
    acc_hit = 1'b0;
  endtask

  task automatic t_zero_len();
    do_reset();
    interval_len = CW'(0);
    run_interval(1, 0, 0, 1, 1, "R2 len 0 single access interval");
    run_interval(1, 1, 0, 1, 2, "R2 len 0 acts as 1");
  endtask

  task automatic t_reset_clears();
    interval_len = CW'(8);
    do_reset();
    check("R1 reset returns weight", weight_big, 1);
    run_interval(8, 8, 0, 1, 1, "R6 perfect rate after reset");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_climb_and_cap();
        t_cross_length();
        t_idle_ignored();
        t_zero_len();
        t_reset_clears();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule